// File: doc/BRIEF.md
# Multi-ID Translation Lookup with Permission Check

This block translates an effective address to a real address against a small, fully associative, software-loaded set of translation entries. Each entry is held as three words: a control word (valid, protect, address-space, process ID and page-size code), an effective-page word, and a real-page word whose low bits carry six access-permission flags. Software loads the words one at a time through an index/select/data write port.

A lookup is started by a one-cycle request strobe carrying the effective address, up to three current process IDs, the privilege mode, the instruction and data relocate bits, and the access kind (fetch, load or store). One cycle later the block raises a done pulse together with a registered real address and a status code. The status tells a hit apart from a miss and from two kinds of permission fault, so a trap handler can pick the right exception without another lookup.

Top module: `xl_lookup`

## Requirements
- R1: An entry whose valid flag (control bit 0) is clear never matches; after reset every entry is invalid.
- R2: The page size is 1 KiB shifted left by twice the size code in control bits 7:4 (code 0 = 1 KiB, 1 = 4 KiB, 2 = 16 KiB, 3 = 64 KiB, ...); address bits below the page size are excluded from the page compare, and codes of 11 and above make the whole address offset.
- R3: An entry whose process ID (control bits 15:8) is zero matches any ID; otherwise it must equal an ID being tried.
- R4: The primary ID is always tried; the second and then the third ID are tried as well, each only when non-zero.
- R5: On a hit or a permission fault the real address is the entry's real-page bits above the page size joined with the effective-address bits below it; on a miss the real address is zero.
- R6: Real-page bits 0..5 are user-read, user-write, user-execute, supervisor-read, supervisor-write, supervisor-execute; user mode consults the first three, supervisor mode the last three.
- R7: The entry's address-space flag (control bit 2) must equal the instruction-relocate input on a fetch and the data-relocate input on a load or store; a mismatch counts as no match.
- R8: Status codes (3-bit two's complement): 0 (000) hit with permission, -1 (111) miss, -2 (110) load or store without read or write permission, -3 (101) fetch without execute permission.
- R9: When several entries match, the lowest-numbered one alone decides the status and the real address.
- R10: Done is high exactly in the cycle after a request; status and real address change only then and hold otherwise.
- R11: A write stores the data into the entry at the given index: select 0 = control word, 1 = effective page, 2 = real page, 3 = no effect.
- R12: After reset done is low, status is miss (111) and the real address is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Entry word write enable |
| wr_idx | input | 4 | Entry index to write |
| wr_sel | input | 2 | Word select: 0 control, 1 effective page, 2 real page |
| wr_data | input | 32 | Word value to write |
| req | input | 1 | Lookup request strobe |
| req_va | input | 32 | Effective address |
| req_pid0 | input | 8 | Primary process ID |
| req_pid1 | input | 8 | Second process ID, tried when non-zero |
| req_pid2 | input | 8 | Third process ID, tried when non-zero |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| req_irel | input | 1 | Instruction-relocate bit |
| req_drel | input | 1 | Data-relocate bit |
| req_fetch | input | 1 | 1 = instruction fetch |
| req_write | input | 1 | 1 = store, 0 = load (ignored on fetch) |
| done | output | 1 | Result valid pulse |
| pa | output | 32 | Real address |
| status | output | 3 | Result code |

## Verification
Lookups sweep page sizes of 1, 4, 16 KiB and the whole-address case with addresses on both sides of each page edge, which separates a correct offset mask from one that is off by a bit pair. Each permission flag is tried in both privilege modes and for fetch, load and store, so a swapped user/supervisor group or a read/write mix-up gives a wrong status code. Overlapping entries of different sizes and process IDs show whether the lowest index wins and whether a wildcard entry catches what a specific one misses; secondary-ID patterns with zero and non-zero values, relocate-bit mismatches and an entry invalidated by a rewrite tell the miss paths apart.

// File: rtl/xl_pkg.sv
package xl_pkg;

  // control word field positions (decoded by the match logic)
  localparam int CTL_VALID   = 0;
  localparam int CTL_PROT    = 1;
  localparam int CTL_ASPACE  = 2;
  localparam int CTL_SIZE_LO = 4;
  localparam int CTL_PID_LO  = 8;

  // permission flag positions in the real-page word
  localparam int PRM_UR = 0;
  localparam int PRM_UW = 1;
  localparam int PRM_UX = 2;
  localparam int PRM_SR = 3;
  localparam int PRM_SW = 4;
  localparam int PRM_SX = 5;

  // word select on the write port
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_EPN  = 2'd1;
  localparam logic [1:0] SEL_RPN  = 2'd2;

  typedef enum logic [2:0] {
    XL_HIT     = 3'b000,
    XL_MISS    = 3'b111,
    XL_RWFAULT = 3'b110,
    XL_XFAULT  = 3'b101
  } xl_status_e;

endpackage

// File: rtl/xl_entry_array.sv
module xl_entry_array
  import xl_pkg::*;
#(
  parameter int NENT = 16,
  parameter int AW   = 32,
  localparam int IW  = $clog2(NENT)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IW-1:0]            wr_idx,
  input  logic [1:0]               wr_sel,
  input  logic [AW-1:0]            wr_data,
  output logic [NENT-1:0][AW-1:0]  ctrl_o,
  output logic [NENT-1:0][AW-1:0]  epn_o,
  output logic [NENT-1:0][AW-1:0]  rpn_o
);

  logic [NENT-1:0][AW-1:0] ctrl_q, epn_q, rpn_q;

  for (genvar e = 0; e < NENT; e++) begin : g_ent
    logic hit_idx, ce_ctrl, ce_epn, ce_rpn;
    assign hit_idx = wr_en && (wr_idx == IW'(e));
    assign ce_ctrl = hit_idx && (wr_sel == SEL_CTRL);
    assign ce_epn  = hit_idx && (wr_sel == SEL_EPN);
    assign ce_rpn  = hit_idx && (wr_sel == SEL_RPN);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_q[e] <= '0;
        epn_q[e]  <= '0;
        rpn_q[e]  <= '0;
      end else begin
        if (ce_ctrl) ctrl_q[e] <= wr_data;
        if (ce_epn)  epn_q[e]  <= wr_data;
        if (ce_rpn)  rpn_q[e]  <= wr_data;
      end
    end
  end

  assign ctrl_o = ctrl_q;
  assign epn_o  = epn_q;
  assign rpn_o  = rpn_q;

endmodule

// File: rtl/xl_entry_match.sv
module xl_entry_match
  import xl_pkg::*;
#(
  parameter int AW     = 32,
  parameter int PIDW   = 8,
  parameter int SZW    = 4,
  parameter int MINOFF = 10
) (
  input  logic [AW-1:0]   ctrl_i,
  input  logic [AW-1:0]   epn_i,
  input  logic [AW-1:0]   rpn_i,
  input  logic [AW-1:0]   va_i,
  input  logic [PIDW-1:0] pid0_i,
  input  logic [PIDW-1:0] pid1_i,
  input  logic [PIDW-1:0] pid2_i,
  input  logic            irel_i,
  input  logic            drel_i,
  input  logic            fetch_i,
  output logic            hit_o,
  output logic [AW-1:0]   pa_o
);

  logic            valid, aspace;
  logic [SZW-1:0]  size_code;
  logic [PIDW-1:0] ent_pid;
  logic [AW-1:0]   page_mask;
  logic            pid_ok, as_ok, page_ok;
  int              off_bits;

  assign valid     = ctrl_i[CTL_VALID];
  assign aspace    = ctrl_i[CTL_ASPACE];
  assign size_code = ctrl_i[CTL_SIZE_LO +: SZW];
  assign ent_pid   = ctrl_i[CTL_PID_LO +: PIDW];

  // offset width grows by two bits per size step
  always_comb begin
    off_bits = MINOFF + 2 * int'(size_code);
    for (int b = 0; b < AW; b++) begin
      page_mask[b] = (b >= off_bits);
    end
  end

  // wildcard ID, primary ID, then secondary IDs only when non-zero
  always_comb begin
    pid_ok = (ent_pid == '0) || (ent_pid == pid0_i);
    if (pid1_i != '0 && ent_pid == pid1_i) pid_ok = 1'b1;
    if (pid2_i != '0 && ent_pid == pid2_i) pid_ok = 1'b1;
  end

  assign as_ok   = (aspace == (fetch_i ? irel_i : drel_i));
  assign page_ok = (((va_i ^ epn_i) & page_mask) == '0);
  assign hit_o   = valid && pid_ok && as_ok && page_ok;
  assign pa_o    = (rpn_i & page_mask) | (va_i & ~page_mask);

  logic unused_ctrl;
  assign unused_ctrl = ^{ctrl_i[CTL_PROT], ctrl_i[3], ctrl_i[AW-1:CTL_PID_LO+PIDW]};

endmodule

// File: rtl/xl_first_hit.sv
module xl_first_hit #(
  parameter int NENT = 16,
  localparam int IW  = $clog2(NENT)
) (
  input  logic [NENT-1:0] hit_i,
  output logic            any_o,
  output logic [IW-1:0]   idx_o
);

  always_comb begin
    any_o = |hit_i;
    idx_o = '0;
    for (int i = NENT - 1; i >= 0; i--) begin
      if (hit_i[i]) idx_o = IW'(i);
    end
  end

endmodule

// File: rtl/xl_lookup.sv
module xl_lookup
  import xl_pkg::*;
#(
  parameter int NENT   = 16,
  parameter int AW     = 32,
  parameter int PIDW   = 8,
  parameter int SZW    = 4,
  parameter int MINOFF = 10,
  localparam int IW    = $clog2(NENT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [1:0]      wr_sel,
  input  logic [AW-1:0]   wr_data,
  input  logic            req,
  input  logic [AW-1:0]   req_va,
  input  logic [PIDW-1:0] req_pid0,
  input  logic [PIDW-1:0] req_pid1,
  input  logic [PIDW-1:0] req_pid2,
  input  logic            req_user,
  input  logic            req_irel,
  input  logic            req_drel,
  input  logic            req_fetch,
  input  logic            req_write,
  output logic            done,
  output logic [AW-1:0]   pa,
  output logic [2:0]      status
);

  logic [NENT-1:0][AW-1:0] ctrl_w, epn_w, rpn_w, pa_w;
  logic [NENT-1:0]         hit_w;
  logic                    any_hit;
  logic [IW-1:0]           win_idx;

  xl_entry_array #(.NENT(NENT), .AW(AW)) i_array (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_sel(wr_sel), .wr_data(wr_data),
    .ctrl_o(ctrl_w), .epn_o(epn_w), .rpn_o(rpn_w)
  );

  for (genvar e = 0; e < NENT; e++) begin : g_cmp
    xl_entry_match #(.AW(AW), .PIDW(PIDW), .SZW(SZW), .MINOFF(MINOFF)) i_match (
      .ctrl_i(ctrl_w[e]), .epn_i(epn_w[e]), .rpn_i(rpn_w[e]),
      .va_i(req_va), .pid0_i(req_pid0), .pid1_i(req_pid1), .pid2_i(req_pid2),
      .irel_i(req_irel), .drel_i(req_drel), .fetch_i(req_fetch),
      .hit_o(hit_w[e]), .pa_o(pa_w[e])
    );
  end

  xl_first_hit #(.NENT(NENT)) i_pick (
    .hit_i(hit_w), .any_o(any_hit), .idx_o(win_idx)
  );

  // permission decision on the winning entry
  logic [AW-1:0] win_rpn;
  logic          may_r, may_w, may_x;
  xl_status_e    status_nx;
  logic [AW-1:0] pa_nx;

  always_comb begin
    win_rpn = rpn_w[win_idx];
    may_r   = req_user ? win_rpn[PRM_UR] : win_rpn[PRM_SR];
    may_w   = req_user ? win_rpn[PRM_UW] : win_rpn[PRM_SW];
    may_x   = req_user ? win_rpn[PRM_UX] : win_rpn[PRM_SX];
    if (!any_hit) begin
      status_nx = XL_MISS;
      pa_nx     = '0;
    end else begin
      pa_nx = pa_w[win_idx];
      if (req_fetch)      status_nx = may_x ? XL_HIT : XL_XFAULT;
      else if (req_write) status_nx = may_w ? XL_HIT : XL_RWFAULT;
      else                status_nx = may_r ? XL_HIT : XL_RWFAULT;
    end
  end

  // result registers, loaded only on a request
  logic          done_q;
  xl_status_e    status_q;
  logic [AW-1:0] pa_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      status_q <= XL_MISS;
      pa_q     <= '0;
    end else begin
      done_q <= req;
      if (req) begin
        status_q <= status_nx;
        pa_q     <= pa_nx;
      end
    end
  end

  assign done   = done_q;
  assign status = status_q;
  assign pa     = pa_q;

endmodule

// File: rtl/xl_lookup_chk.sv
module xl_lookup_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          req_fetch,
  input logic          done,
  input logic [AW-1:0] pa,
  input logic [2:0]    status
);

  // R10
  done_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> done);

  // R10
  no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !done);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> ($stable(status) && $stable(pa)));

  // R8
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (status == 3'b000 || status == 3'b111 || status == 3'b110 || status == 3'b101));

  // R5
  miss_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 3'b111) |-> (pa == '0));

  // R8
  xfault_only_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !req_fetch) |=> (status != 3'b101));

  // R8
  rwfault_only_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && req_fetch) |=> (status != 3'b110));

endmodule

bind xl_lookup xl_lookup_chk #(.AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .req_fetch(req_fetch),
  .done(done), .pa(pa), .status(status)
);

// File: tb/test_xl_lookup.sv
`timescale 1ns/1ps
module test_xl_lookup;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic        req;
  logic [31:0] req_va;
  logic [7:0]  req_pid0, req_pid1, req_pid2;
  logic        req_user, req_irel, req_drel, req_fetch, req_write;
  logic        done;
  logic [31:0] pa;
  logic [2:0]  status;

  always #2.5 clk = ~clk;

  xl_lookup i_xl_lookup (.*);

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  localparam logic [2:0] S_HIT = 3'b000, S_MISS = 3'b111, S_RW = 3'b110, S_X = 3'b101;

  // {va, pid0, pid1, pid2, {user,irel,drel,fetch,write}, req tag, status, pa}
  localparam int NV = 23;
  localparam logic [99:0] VECS [NV] = '{
    {32'h1000_0ABC, 8'h05, 8'h00, 8'h00, 5'b00000, 4'd5,  S_HIT,  32'h8000_0ABC}, // R5 sup load
    {32'h1000_0ABC, 8'h05, 8'h00, 8'h00, 5'b10001, 4'd6,  S_HIT,  32'h8000_0ABC}, // R6 user store
    {32'h1000_0ABC, 8'h05, 8'h00, 8'h00, 5'b10010, 4'd8,  S_X,    32'h8000_0ABC}, // R8 user fetch no UX
    {32'h1000_0ABC, 8'h05, 8'h00, 8'h00, 5'b00010, 4'd6,  S_HIT,  32'h8000_0ABC}, // R6 sup fetch
    {32'h1000_0ABC, 8'h06, 8'h00, 8'h00, 5'b00000, 4'd3,  S_MISS, 32'h0000_0000}, // R3 wrong ID
    {32'h1000_1000, 8'h05, 8'h00, 8'h00, 5'b00000, 4'd2,  S_MISS, 32'h0000_0000}, // R2 next 4K page
    {32'h2000_07FF, 8'h42, 8'h00, 8'h00, 5'b10010, 4'd3,  S_HIT,  32'h9000_0BFF}, // R3 wildcard, R2 1K
    {32'h2000_0800, 8'h42, 8'h00, 8'h00, 5'b10010, 4'd2,  S_MISS, 32'h0000_0000}, // R2 past 1K page
    {32'h2000_0410, 8'h01, 8'h00, 8'h00, 5'b10000, 4'd6,  S_RW,   32'h9000_0810}, // R6 user no UR
    {32'h2000_0410, 8'h01, 8'h00, 8'h00, 5'b00000, 4'd6,  S_HIT,  32'h9000_0810}, // R6 sup SR
    {32'h2000_0410, 8'h01, 8'h00, 8'h00, 5'b00001, 4'd8,  S_RW,   32'h9000_0810}, // R8 sup no SW
    {32'h3000_7FFC, 8'h07, 8'h00, 8'h00, 5'b00100, 4'd2,  S_HIT,  32'hA000_FFFC}, // R2 16K, R7
    {32'h3000_7FFC, 8'h07, 8'h00, 8'h00, 5'b00000, 4'd7,  S_MISS, 32'h0000_0000}, // R7 data space
    {32'h3000_7FFC, 8'h07, 8'h00, 8'h00, 5'b01010, 4'd7,  S_HIT,  32'hA000_FFFC}, // R7 fetch space
    {32'h3000_7FFC, 8'h07, 8'h00, 8'h00, 5'b00110, 4'd7,  S_MISS, 32'h0000_0000}, // R7 fetch uses irel
    {32'h4000_0010, 8'h00, 8'h00, 8'h00, 5'b00000, 4'd1,  S_MISS, 32'h0000_0000}, // R1 invalid entry
    {32'h5000_0123, 8'h09, 8'h00, 8'h00, 5'b10000, 4'd9,  S_HIT,  32'hB000_0123}, // R9 lower wins
    {32'h5000_0123, 8'h0A, 8'h00, 8'h00, 5'b10000, 4'd9,  S_RW,   32'hC000_0123}, // R9 wildcard behind
    {32'h5000_0123, 8'h0A, 8'h00, 8'h00, 5'b00010, 4'd8,  S_X,    32'hC000_0123}, // R8 no SX
    {32'h6000_0044, 8'h01, 8'h03, 8'h00, 5'b00000, 4'd4,  S_HIT,  32'hD000_0044}, // R4 second ID
    {32'h6000_0044, 8'h01, 8'h00, 8'h03, 5'b00000, 4'd4,  S_HIT,  32'hD000_0044}, // R4 third ID
    {32'h6000_0044, 8'h01, 8'h02, 8'h04, 5'b00000, 4'd4,  S_MISS, 32'h0000_0000}, // R4 none match
    {32'h5000_1000, 8'h09, 8'h00, 8'h00, 5'b10000, 4'd9,  S_RW,   32'hC000_1000}  // R9 64K covers
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // drive a request, return the result one cycle later at the negedge
  task automatic look(input logic [31:0] va, input logic [7:0] p0, p1, p2,
                      input logic [4:0] fl);
    @(negedge clk);
    req = 1'b1; req_va = va; req_pid0 = p0; req_pid1 = p1; req_pid2 = p2;
    {req_user, req_irel, req_drel, req_fetch, req_write} = fl;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic expect_res(input string tag, input logic [2:0] st, input logic [31:0] ea);
    chk(done == 1'b1, {tag, " done"}, 32'(done), 32'd1);
    chk(status == st, {tag, " status"}, 32'(status), 32'(st));
    chk(pa == ea, {tag, " pa"}, pa, ea);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_sel = '0; wr_data = '0;
    req = 1'b0; req_va = '0; req_pid0 = '0; req_pid1 = '0; req_pid2 = '0;
    {req_user, req_irel, req_drel, req_fetch, req_write} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(done == 1'b0, "R12 done", 32'(done), 32'd0);
    chk(status == S_MISS, "R12 status", 32'(status), 32'(S_MISS));
    chk(pa == 32'h0, "R12 pa", pa, 32'h0);

    // R1 all entries invalid after reset: a wildcard lookup misses
    look(32'h0000_0000, 8'h00, 8'h00, 8'h00, 5'b00000);
    expect_res("R1 empty", S_MISS, 32'h0);

    // R11 load entries through the write port
    wr(4'd0, 2'd0, 32'h0000_0511); wr(4'd0, 2'd1, 32'h1000_0000); wr(4'd0, 2'd2, 32'h8000_003B);
    wr(4'd1, 2'd0, 32'h0000_0001); wr(4'd1, 2'd1, 32'h2000_0400); wr(4'd1, 2'd2, 32'h9000_080C);
    wr(4'd2, 2'd0, 32'h0000_0725); wr(4'd2, 2'd1, 32'h3000_4000); wr(4'd2, 2'd2, 32'hA000_C03F);
    wr(4'd3, 2'd0, 32'h0000_0010); wr(4'd3, 2'd1, 32'h4000_0000); wr(4'd3, 2'd2, 32'hF000_003F);
    wr(4'd4, 2'd0, 32'h0000_0911); wr(4'd4, 2'd1, 32'h5000_0000); wr(4'd4, 2'd2, 32'hB000_003F);
    wr(4'd5, 2'd0, 32'h0000_0031); wr(4'd5, 2'd1, 32'h5000_0000); wr(4'd5, 2'd2, 32'hC000_0000);
    wr(4'd6, 2'd0, 32'h0000_0311); wr(4'd6, 2'd1, 32'h6000_0000); wr(4'd6, 2'd2, 32'hD000_003F);

    for (int i = 0; i < NV; i++) begin
      logic [99:0] v;
      string tag;
      v = VECS[i];
      look(v[99:68], v[67:60], v[59:52], v[51:44], v[43:39]);
      tag = $sformatf("R%0d vec%0d", v[38:35], i);
      expect_res(tag, v[34:32], v[31:0]);
    end

    // R10 done is a single pulse and the result holds while idle
    @(negedge clk);
    chk(done == 1'b0, "R10 done low", 32'(done), 32'd0);
    chk(status == S_RW && pa == 32'hC000_1000, "R10 hold", pa, 32'hC000_1000);

    // R2 size code 11: whole address is offset
    wr(4'd15, 2'd0, 32'h0000_7FB1); wr(4'd15, 2'd1, 32'h0000_0000); wr(4'd15, 2'd2, 32'hFFFF_F03F);
    look(32'h7777_7777, 8'h7F, 8'h00, 8'h00, 5'b00000);
    expect_res("R2 size11", S_HIT, 32'h7777_7777);
    // R2 size code 15 clamps to the whole address
    wr(4'd15, 2'd0, 32'h0000_7FF1);
    look(32'h1234_5678, 8'h7F, 8'h00, 8'h00, 5'b00000);
    expect_res("R2 size15", S_HIT, 32'h1234_5678);

    // R11 select 3 leaves entry 6 unchanged
    wr(4'd6, 2'd3, 32'h0000_0000);
    look(32'h6000_0044, 8'h03, 8'h00, 8'h00, 5'b00000);
    expect_res("R11 sel3", S_HIT, 32'hD000_0044);

    // R1 R11 clearing the valid flag of entry 0 makes it miss
    wr(4'd0, 2'd0, 32'h0000_0510);
    look(32'h1000_0ABC, 8'h05, 8'h00, 8'h00, 5'b00000);
    expect_res("R1 cleared", S_MISS, 32'h0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule